// File: doc/BRIEF.md
# Seeded Identity Code Builder

This block assembles a 64-bit identity code for a device from two inputs produced elsewhere on the chip. A 32-bit seed word, delivered with a one-cycle valid strobe, becomes the starting state of a 32-bit linear feedback shift register. The seed comes from a challenge-response delay fingerprint circuit. A serial stream of raw random bits, each with its own valid strobe, comes from a free-running oscillator entropy source. Each raw bit is combined with one bit that the register shifts out.

The combined bits go through a pair-based bias-removal stage. Each bit that survives that stage is shifted into the code register. After 64 surviving bits the block raises `done` and holds the code until software-independent control logic issues the next `start` pulse. The entropy and fingerprint circuits are outside this block and appear only as input ports.

Top module: `idgen_code_builder`

## Requirements
- R1: A synchronous active-high `rst` clears `code` to zero and `done` to 0, and leaves the block with no seed held.
- R2: While no seed is held, a `seed_valid` strobe loads `seed_word` as the register state. While a seed is held, further `seed_valid` strobes are ignored until the next `start`.
- R3: A seed of all zeros is replaced by the constant 32'h9E3779B9 when it is loaded, so the register never holds zero.
- R4: The register shifts right. Its output bit is state bit 0, and its new bit 31 is the XOR of state bits 0, 10, 30 and 31, which gives the polynomial x^32+x^22+x^2+x+1. It advances exactly once for each raw bit that is taken. A raw bit is taken when `raw_valid` is high, a seed is held and `done` is low.
- R5: Each raw bit that is taken is XORed with the register output bit of that same cycle to form one mixed bit.
- R6: Mixed bits are grouped in non-overlapping pairs, in arrival order. The pair 0 then 1 yields a 0, and the pair 1 then 0 yields a 1. The pairs 00 and 11 yield nothing.
- R7: Each yielded bit enters `code` at bit 0, and the earlier bits move up one position.
- R8: `done` rises on the clock edge that accepts the 64th yielded bit. After that, `code` and `done` hold, and raw bits are ignored.
- R9: A `start` pulse clears `code`, the yielded-bit count, the pair state, `done` and the held seed. In the same cycle it overrides any `seed_valid` or `raw_valid`.
- R10: Raw bits that arrive while no seed is held, including in the cycle in which the seed is loaded, are ignored. They do not advance the register and do not enter a pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a new code; clears progress and the held seed |
| seed_valid | input | 1 | Strobe qualifying `seed_word` |
| seed_word | input | 32 | Fingerprint seed for the shift register |
| raw_valid | input | 1 | Strobe qualifying `raw_bit` |
| raw_bit | input | 1 | One raw entropy bit |
| code | output | 64 | Identity code being assembled, final when `done` is high |
| done | output | 1 | High once 64 bits have been accepted |

## Verification
The assertions assume that `rst` is held for at least one edge before any checked activity, and that `start` is a single-cycle pulse. Beyond that, they place no constraint on how the strobes are spaced.

The stimulus drives all inputs half a cycle away from the sampling edge. It varies the density of `raw_valid` at random, and it deliberately sends seeds, raw bits and `start` in the orders that R2, R9 and R10 single out. Directed raw bits are chosen against the bench's own model of the register output, so that the pairs reaching the bias-removal stage are exactly the ones intended.

// File: rtl/idgen_pkg.sv
package idgen_pkg;

  localparam int unsigned LFSR_W = 32;
  localparam logic [LFSR_W-1:0] ZERO_SEED_SUB = 32'h9E37_79B9;

  typedef struct packed {
    logic held;
    logic first;
  } pair_t;

  // taps for x^32 + x^22 + x^2 + x + 1 on a right-shifting register
  function automatic logic lfsr_feedback(input logic [LFSR_W-1:0] s);
    return s[0] ^ s[10] ^ s[30] ^ s[31];
  endfunction

  function automatic logic [LFSR_W-1:0] lfsr_advance(input logic [LFSR_W-1:0] s);
    return {lfsr_feedback(s), s[LFSR_W-1:1]};
  endfunction

  function automatic logic [LFSR_W-1:0] seed_fix(input logic [LFSR_W-1:0] s);
    return (s == '0) ? ZERO_SEED_SUB : s;
  endfunction

  // a pair yields a bit only when its two members differ; the yield is the first
  function automatic logic pair_yields(input pair_t p, input logic b);
    return p.held && (p.first != b);
  endfunction

endpackage

// File: rtl/idgen_lfsr.sv
module idgen_lfsr
  import idgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              load,
  input  logic [LFSR_W-1:0] seed,
  input  logic              step,
  output logic              out_bit,
  output logic              armed,
  output logic [LFSR_W-1:0] state
);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= '0;
      armed <= 1'b0;
    end else if (clr) begin
      armed <= 1'b0;
    end else if (load) begin
      state <= seed_fix(seed);
      armed <= 1'b1;
    end else if (step) begin
      state <= lfsr_advance(state);
    end
  end

  assign out_bit = state[0];

endmodule

// File: rtl/idgen_vn.sv
module idgen_vn
  import idgen_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic in_valid,
  input  logic in_bit,
  output logic out_valid,
  output logic out_bit
);

  pair_t pair_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pair_q <= '0;
    end else if (in_valid) begin
      if (pair_q.held) begin
        pair_q.held <= 1'b0;
      end else begin
        pair_q.held  <= 1'b1;
        pair_q.first <= in_bit;
      end
    end
  end

  assign out_valid = in_valid && pair_yields(pair_q, in_bit);
  assign out_bit   = pair_q.first;

endmodule

// File: rtl/idgen_packer.sv
module idgen_packer #(
  parameter int unsigned CODE_W = 64,
  localparam int unsigned CNT_W = $clog2(CODE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              in_valid,
  input  logic              in_bit,
  output logic [CODE_W-1:0] code,
  output logic              done,
  output logic [CNT_W-1:0]  count
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(CODE_W - 1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      code  <= '0;
      done  <= 1'b0;
      count <= '0;
    end else if (in_valid && !done) begin
      code  <= {code[CODE_W-2:0], in_bit};
      count <= count + 1'b1;
      if (count == LAST) done <= 1'b1;
    end
  end

endmodule

// File: rtl/idgen_code_builder.sv
module idgen_code_builder
  import idgen_pkg::*;
#(
  parameter int unsigned CODE_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              seed_valid,
  input  logic [31:0]       seed_word,
  input  logic              raw_valid,
  input  logic              raw_bit,
  output logic [CODE_W-1:0] code,
  output logic              done
);

  localparam int unsigned CNT_W = $clog2(CODE_W + 1);

  logic              armed;
  logic              lfsr_bit;
  logic [LFSR_W-1:0] lfsr_state;
  logic              seed_load;
  logic              raw_take;
  logic              mixed_bit;
  logic              acc_valid;
  logic              acc_bit;
  logic [CNT_W-1:0]  acc_count;

  assign seed_load = seed_valid && !armed && !start;
  assign raw_take  = raw_valid && armed && !done && !start;
  assign mixed_bit = raw_bit ^ lfsr_bit;

  idgen_lfsr u_lfsr (
    .clk     (clk),
    .rst     (rst),
    .clr     (start),
    .load    (seed_load),
    .seed    (seed_word),
    .step    (raw_take),
    .out_bit (lfsr_bit),
    .armed   (armed),
    .state   (lfsr_state)
  );

  idgen_vn u_vn (
    .clk       (clk),
    .rst       (rst),
    .clr       (start),
    .in_valid  (raw_take),
    .in_bit    (mixed_bit),
    .out_valid (acc_valid),
    .out_bit   (acc_bit)
  );

  idgen_packer #(.CODE_W(CODE_W)) u_pack (
    .clk      (clk),
    .rst      (rst),
    .clr      (start),
    .in_valid (acc_valid),
    .in_bit   (acc_bit),
    .code     (code),
    .done     (done),
    .count    (acc_count)
  );

endmodule

// File: rtl/idgen_checker.sv
module idgen_checker #(
  parameter int unsigned CODE_W = 64,
  parameter int unsigned CNT_W  = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              done,
  input logic [CODE_W-1:0] code,
  input logic              armed,
  input logic [31:0]       lfsr_state,
  input logic              acc_valid,
  input logic              acc_bit,
  input logic [CNT_W-1:0]  acc_count
);

  // R3: a held seed is never the all-zero state
  a_r3_state_nonzero: assert property (@(posedge clk) disable iff (rst)
    armed |-> lfsr_state != '0);

  // R7: an accepted bit lands in bit 0, the rest move up
  a_r7_shift_in: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !done && !start) |=>
      (code[0] == $past(acc_bit)) && (code[CODE_W-1:1] == $past(code[CODE_W-2:0])));

  // R8: done and the code are held until start
  a_r8_done_hold: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done && $stable(code));

  // R8: the count never passes the code width
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    acc_count <= CNT_W'(CODE_W));

  // R9: start clears the code and done
  a_r9_start_clears: assert property (@(posedge clk) disable iff (rst)
    start |=> !done && code == '0 && !armed);

  // R10: nothing is accepted without a held seed
  a_r10_no_accept_unarmed: assert property (@(posedge clk) disable iff (rst)
    !armed |-> !acc_valid);

endmodule

bind idgen_code_builder idgen_checker #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_idgen_checker (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .done       (done),
  .code       (code),
  .armed      (armed),
  .lfsr_state (lfsr_state),
  .acc_valid  (acc_valid),
  .acc_bit    (acc_bit),
  .acc_count  (acc_count)
);

// File: tb/test_idgen_code_builder.sv
module test_idgen_code_builder;

  logic        clk = 1'b0;
  logic        rst, start, seed_valid, raw_valid, raw_bit;
  logic [31:0] seed_word;
  logic [63:0] code;
  logic        done;

  int unsigned n_checks = 0;
  int unsigned n_fails  = 0;
  bit          finished = 1'b0;

  // bench model
  logic [31:0] m_lfsr;
  logic        m_seeded, m_pend, m_first, m_done;
  logic [63:0] m_code;
  int          m_cnt;

  always #2 clk = ~clk;

  idgen_code_builder i_idgen_code_builder (
    .clk(clk), .rst(rst), .start(start), .seed_valid(seed_valid),
    .seed_word(seed_word), .raw_valid(raw_valid), .raw_bit(raw_bit),
    .code(code), .done(done)
  );

  function automatic logic [31:0] tb_step(input logic [31:0] s);
    logic fb;
    fb = ^(s & 32'hC000_0401);
    return (s >> 1) | ({31'd0, fb} << 31);
  endfunction

  task automatic model_edge(input logic r, st, sv, input logic [31:0] sd, input logic rv, rb);
    logic m;
    if (r) begin
      m_lfsr = 0; m_seeded = 0; m_pend = 0; m_first = 0; m_done = 0; m_code = 0; m_cnt = 0;
    end else if (st) begin
      m_seeded = 0; m_pend = 0; m_done = 0; m_code = 0; m_cnt = 0;
    end else if (!m_seeded) begin
      if (sv) begin
        m_lfsr = (sd == 32'd0) ? 32'h9E37_79B9 : sd;
        m_seeded = 1;
      end
    end else if (rv && !m_done) begin
      m = m_lfsr[0] ^ rb;
      m_lfsr = tb_step(m_lfsr);
      if (!m_pend) begin
        m_pend = 1; m_first = m;
      end else begin
        m_pend = 0;
        if (m_first != m) begin
          m_code = {m_code[62:0], m_first};
          m_cnt++;
          if (m_cnt == 64) m_done = 1;
        end
      end
    end
  endtask

  task automatic check(input string tag);
    n_checks++;
    if (code !== m_code || done !== m_done) begin
      n_fails++;
      $display("FAIL %s code=%h exp=%h done=%b exp=%b", tag, code, m_code, done, m_done);
    end
  endtask

  // drive at negedge, apply at posedge, compare at next negedge
  task automatic tick(input logic r, st, sv, input logic [31:0] sd,
                      input logic rv, rb, input string tag);
    rst = r; start = st; seed_valid = sv; seed_word = sd; raw_valid = rv; raw_bit = rb;
    @(posedge clk);
    model_edge(r, st, sv, sd, rv, rb);
    @(negedge clk);
    check(tag);
  endtask

  task automatic run_random(input int density, input int max_cycles, input string tag);
    for (int i = 0; i < max_cycles && !m_done; i++)
      tick(0, 0, 0, 0, (($urandom % 100) < density), 1'($urandom), tag);
  endtask

  // send one mixed bit of the chosen value
  task automatic send_mixed(input logic want, input string tag);
    tick(0, 0, 0, 0, 1, want ^ m_lfsr[0], tag);
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst = 1; start = 0; seed_valid = 0; seed_word = 0; raw_valid = 0; raw_bit = 0;
    m_lfsr = 0; m_seeded = 0; m_pend = 0; m_first = 0; m_done = 0; m_code = 0; m_cnt = 0;
    @(negedge clk);
    tick(1, 0, 0, 0, 0, 0, "R1 reset");
    tick(0, 0, 0, 0, 0, 0, "R1 idle");

    // R10: raw before the seed, and in the seed cycle, is ignored
    for (int i = 0; i < 6; i++) tick(0, 0, 0, 0, 1, 1'($urandom), "R10 pre-seed raw");
    tick(0, 0, 1, 32'h1357_2468, 1, 1, "R2 seed load");
    // R2: a second seed while held is ignored
    tick(0, 0, 1, 32'hFFFF_0000, 0, 0, "R2 second seed");
    run_random(70, 4000, "R4 R5 R6 R7 dense run");
    if (!m_done) begin n_fails++; $display("FAIL R8 done not reached"); end
    // R8: raw bits after done are ignored
    for (int i = 0; i < 8; i++) tick(0, 0, 0, 0, 1, 1'($urandom), "R8 hold after done");

    // R9: start overrides a same-cycle seed
    tick(0, 1, 1, 32'hDEAD_BEEF, 1, 1, "R9 start clears");
    tick(0, 0, 1, 32'h0000_0000, 0, 0, "R3 zero seed");
    run_random(30, 8000, "R3 R4 sparse run");

    // R6: directed pairs 00,11,01,10,10,01 -> yields 0,1,1,0
    tick(0, 1, 0, 0, 0, 0, "R9 start");
    tick(0, 0, 1, $urandom, 0, 0, "R2 seed");
    send_mixed(0, "R6 00"); send_mixed(0, "R6 00");
    send_mixed(1, "R6 11"); send_mixed(1, "R6 11");
    send_mixed(0, "R6 01"); send_mixed(1, "R6 01");
    send_mixed(1, "R6 10"); send_mixed(0, "R6 10");
    send_mixed(1, "R6 10"); send_mixed(0, "R6 10");
    send_mixed(0, "R6 01"); send_mixed(1, "R6 01");
    n_checks++;
    if (code[3:0] !== 4'b0110 || code[63:4] !== 60'd0) begin
      n_fails++;
      $display("FAIL R6 code=%h exp=%h", code, 64'h6);
    end

    // R1: reset mid-run
    run_random(50, 40, "R7 partial");
    tick(1, 0, 0, 0, 1, 1, "R1 mid-run reset");
    tick(0, 0, 0, 0, 1, 1, "R10 after reset");

    for (int k = 0; k < 3; k++) begin
      tick(0, 1, 0, 0, 0, 0, "R9 start");
      tick(0, 0, 1, $urandom, 0, 0, "R2 seed");
      run_random(20 + 30 * k, 12000, "R4 R5 R6 R7 R8 random run");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(190000 * 4);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule